// File: doc/BRIEF.md
# Resource Descriptor Tag Stream Parser

This block walks a byte stream of plug-and-play resource descriptors and turns it into one summary record per descriptor. Bytes arrive one per valid/ready handshake. The first byte of each descriptor is a tag. The parser reads the tag's format bit and takes the item number and payload length from the tag itself or from the two bytes after it. It then consumes the payload bytes without interpreting them. After the last payload byte it presents a record holding the format, the item number, the length and a flag for reserved item numbers.

The parser holds the input off while a record waits to be accepted. When it meets the end tag it reports that descriptor and then raises `done`. From then on it swallows any further bytes until `restart` is pulsed. The meaning of the payload fields and the stream checksum are left to downstream logic.

Top module: `rsrc_tag_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and both `rec_valid` and `done` are 0.
- R2: A tag byte with bit 7 = 0 is a small item. Its item number is bits [6:3] and its payload length is bits [2:0]. The parser consumes exactly that many payload bytes and then presents a record with `rec_large` = 0, `rec_item` = bits [6:3] and `rec_len` = bits [2:0].
- R3: A tag byte with bit 7 = 1 is a large item, and its item number is bits [6:0]. The next two bytes form a 16-bit payload length, low byte first. The parser consumes that many payload bytes and then presents a record with `rec_large` = 1.
- R4: A descriptor with a zero payload length presents its record in the cycle after its last tag or length byte is accepted, and no payload byte is consumed.
- R5: A small item whose number is 0xA to 0xD sets `rec_err`. All other small item numbers clear it.
- R6: A large item whose number is 0x07 or higher sets `rec_err`. Large item numbers 0x00 to 0x06 clear it.
- R7: Small item number 0xF is the end tag. Its record is presented at once, with the length taken from the tag and no payload consumed. Once that record is accepted, `done` is 1. From then on, input bytes are accepted and discarded and no record appears.
- R8: While `rec_valid` is 1, `in_ready` is 0.
- R9: A presented record keeps `rec_valid` and all of its fields unchanged until the cycle in which `rec_ready` is 1.
- R10: A `restart` pulse drops any pending record, clears `done` and returns the parser to waiting for a tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous return to the tag-waiting state |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser accepts the input byte this cycle |
| rec_valid | output | 1 | A descriptor record is presented |
| rec_ready | input | 1 | Consumer takes the record this cycle |
| rec_large | output | 1 | 1 for a large item, 0 for a small item |
| rec_item | output | 7 | Item number (small items use the low 4 bits) |
| rec_len | output | 16 | Payload length in bytes |
| rec_err | output | 1 | Item number lies in a reserved range |
| done | output | 1 | End tag has been consumed |

## Verification
The bench sends every possible small tag byte and every large item number. This catches a parser that mixes up the item and length fields, or that misplaces a reserved-range boundary: the record or its error flag would come out wrong for at least one value. Large lengths of 0, 256 and 300 check the byte order of the length field. A swapped or dropped high byte would make the parser skip the wrong number of bytes, so the next record would be wrong or would never appear. Records are held back for several cycles to confirm that they stay stable and that the input stays stalled, and bytes are sent after the end tag to confirm they are swallowed. A restart is issued both after done and while a record is pending, and the bench checks that a normal descriptor parses correctly afterwards.

// File: rtl/rsrc_tag_parser.sv
module rsrc_tag_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic        rec_large,
  output logic [6:0]  rec_item,
  output logic [15:0] rec_len,
  output logic        rec_err,
  output logic        done
);
  typedef enum logic [2:0] {S_TAG, S_LEN_LO, S_LEN_HI, S_SKIP, S_EMIT, S_DONE} st_t;

  st_t         st;
  logic [15:0] cnt;
  logic        end_seen;
  logic        take;
  logic [3:0]  s_item;
  logic [2:0]  s_len;
  logic [15:0] l_len;

  assign in_ready  = (st != S_EMIT);
  assign rec_valid = (st == S_EMIT);
  assign done      = (st == S_DONE);
  assign take      = in_valid && in_ready;
  assign s_item    = in_data[6:3];
  assign s_len     = in_data[2:0];
  assign l_len     = {in_data, rec_len[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_TAG;
      cnt       <= '0;
      end_seen  <= 1'b0;
      rec_large <= 1'b0;
      rec_item  <= '0;
      rec_len   <= '0;
      rec_err   <= 1'b0;
    end else if (restart) begin
      st       <= S_TAG;
      end_seen <= 1'b0;
    end else begin
      case (st)
        S_TAG: if (take) begin
          if (!in_data[7]) begin
            rec_large <= 1'b0;
            rec_item  <= {3'b000, s_item};
            rec_len   <= {13'd0, s_len};
            cnt       <= {13'd0, s_len};
            rec_err   <= (s_item >= 4'hA) && (s_item <= 4'hD);
            end_seen  <= (s_item == 4'hF);
            st        <= ((s_len == 3'd0) || (s_item == 4'hF)) ? S_EMIT : S_SKIP;
          end else begin
            rec_large <= 1'b1;
            rec_item  <= in_data[6:0];
            rec_err   <= (in_data[6:0] >= 7'h07);
            end_seen  <= 1'b0;
            st        <= S_LEN_LO;
          end
        end
        S_LEN_LO: if (take) begin
          rec_len[7:0] <= in_data;
          st           <= S_LEN_HI;
        end
        S_LEN_HI: if (take) begin
          rec_len[15:8] <= in_data;
          cnt           <= l_len;
          st            <= (l_len == 16'd0) ? S_EMIT : S_SKIP;
        end
        S_SKIP: if (take) begin
          cnt <= cnt - 16'd1;
          if (cnt == 16'd1) st <= S_EMIT;
        end
        S_EMIT: if (rec_ready) st <= end_seen ? S_DONE : S_TAG;
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

module rsrc_tag_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        in_ready,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic        rec_large,
  input logic [6:0]  rec_item,
  input logic [15:0] rec_len,
  input logic        rec_err,
  input logic        done
);
  AST_SMALL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_large |-> (rec_len < 16'd8) && (rec_item < 7'd16)); // R2
  AST_SMALL_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_large |-> rec_err == ((rec_item >= 7'd10) && (rec_item <= 7'd13))); // R5
  AST_LARGE_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_large |-> rec_err == (rec_item >= 7'd7)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !restart |=> done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec_valid && in_ready); // R7
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !in_ready); // R8
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n || restart)
    rec_valid && !rec_ready |=> rec_valid && $stable({rec_large, rec_item, rec_len, rec_err})); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !rec_valid && !done); // R10
endmodule

bind rsrc_tag_parser rsrc_tag_parser_chk i_chk (.*);

// File: tb/test_rsrc_tag_parser.sv
`timescale 1ns/1ps
module test_rsrc_tag_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic        rec_large;
  logic [6:0]  rec_item;
  logic [15:0] rec_len;
  logic        rec_err;
  logic        done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rsrc_tag_parser i_rsrc_tag_parser (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_large(rec_large), .rec_item(rec_item), .rec_len(rec_len),
    .rec_err(rec_err), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_rec(input string req, input bit lg, input logic [6:0] item,
                            input logic [15:0] len, input bit err, input int hold);
    logic [25:0] got, want;
    bit ok;
    want = {lg, item, len, err};
    got  = {rec_large, rec_item, rec_len, rec_err};
    ok   = rec_valid && (got == want);
    for (int h = 0; h < hold; h++) begin
      rec_ready = 1'b0;
      @(negedge clk);
      if (!rec_valid || in_ready || ({rec_large, rec_item, rec_len, rec_err} != want)) ok = 0;
    end
    chk(ok, req, "record {valid,large,item,len,err}",
        {5'd0, rec_valid, rec_large, rec_item, rec_len, rec_err},
        {5'd0, 1'b1, want});
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1 && rec_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
        {29'd0, in_ready, rec_valid, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4 / R5 every small tag except the end tag
    for (int t = 0; t < 128; t++) begin
      int item, len;
      item = t >> 3;
      len  = t & 7;
      if (item != 15) begin
        send(t[7:0]);
        for (int p = 0; p < len; p++) send(8'(8'hA5 + p));
        expect_rec(len == 0 ? "R4" : ((item >= 10 && item <= 13) ? "R5" : "R2"),
                   1'b0, 7'(item), 16'(len), (item >= 10 && item <= 13), t % 3);
      end
    end

    // R3 / R6 every large item number, short lengths
    for (int it = 0; it < 128; it++) begin
      int len;
      len = it % 4;
      send(8'(8'h80 | it));
      send(8'(len));
      send(8'h00);
      for (int p = 0; p < len; p++) send(8'(8'hF0 ^ p));
      expect_rec(it >= 7 ? "R6" : (len == 0 ? "R4" : "R3"),
                 1'b1, 7'(it), 16'(len), it >= 7, (it % 5 == 0) ? 4 : 0);
    end

    // R3 high length byte: 256 and 300 payload bytes, low byte first
    send(8'h81); send(8'h00); send(8'h01);
    for (int p = 0; p < 256; p++) send(8'hFF);
    expect_rec("R3", 1'b1, 7'h01, 16'd256, 1'b0, 2);
    send(8'h86); send(8'h2C); send(8'h01);
    for (int p = 0; p < 300; p++) send(8'h79);
    expect_rec("R3", 1'b1, 7'h06, 16'd300, 1'b0, 1);

    // R8 input held off while record pending
    send(8'h20);
    @(negedge clk);
    chk(in_ready == 1'b0, "R8", "in_ready while record pending", {31'd0, in_ready}, 32'd0);
    expect_rec("R9", 1'b0, 7'h04, 16'd0, 1'b0, 3);

    // R7 end tag with length 1: record at once, then done
    send(8'h79);
    expect_rec("R7", 1'b0, 7'h0F, 16'd1, 1'b0, 2);
    chk(done == 1'b1 && rec_valid == 1'b0, "R7", "done after end tag",
        {30'd0, done, rec_valid}, 32'h2);
    send(8'h08); send(8'h81); send(8'h10);
    @(negedge clk);
    chk(done == 1'b1 && rec_valid == 1'b0 && in_ready == 1'b1, "R7", "bytes after end ignored",
        {29'd0, done, rec_valid, in_ready}, 32'h5);

    // R10 restart after done
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(done == 1'b0 && in_ready == 1'b1, "R10", "restart clears done",
        {30'd0, done, in_ready}, 32'h1);
    send(8'h10);
    expect_rec("R10", 1'b0, 7'h02, 16'd0, 1'b0, 0);

    // R10 restart drops a pending record
    send(8'h18);
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(rec_valid == 1'b0 && in_ready == 1'b1, "R10", "restart drops record",
        {30'd0, rec_valid, in_ready}, 32'h1);
    send(8'h22); send(8'h11); send(8'h22);
    expect_rec("R10", 1'b0, 7'h04, 16'd2, 1'b0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule